// File: doc/BRIEF.md
# Serial EEPROM Word Write Sequencer

This block stores one 16-bit word into a serial-bus EEPROM. A request carries a word offset and a data word. The block first checks the offset against the configured device size in words. An offset that is out of range ends at once with an error and leaves the bus idle. A valid request produces two chip-select frames. The first frame carries only the write-enable command. Chip select then goes high for a standby cycle. The second frame carries the write opcode, the byte address and the data word, with the two data bytes swapped. After the second frame the block waits a programmable number of cycles for the device to program, then pulses `done`.

The bus runs in SPI mode 0. SCK rests low, the device samples MOSI on the rising edge of SCK, and MOSI changes only on the falling edge. The length of each SCK half period is a parameter. A device can use 8 or 16 address bits. With 8 address bits, byte address bit 8 travels inside the write opcode.

The control FSM has these states. ST_IDLE waits for a request. ST_REJECT gives the error completion. ST_WREN sends the write-enable frame. ST_STANDBY holds chip select high. ST_WRITE sends the write frame. ST_SETTLE counts out the programming delay. ST_DONE gives the normal completion. The transitions are:
- ST_IDLE goes to ST_REJECT when the offset is out of range, and to ST_WREN otherwise.
- ST_REJECT and ST_DONE return to ST_IDLE.
- ST_WREN goes to ST_STANDBY, and ST_WRITE goes to ST_SETTLE, each when the shift engine finishes its frame.
- ST_STANDBY goes to ST_WRITE after one cycle.
- ST_SETTLE goes to ST_DONE when the delay counter reaches zero.

Top module: `eeprom_word_writer`

## Requirements
- R1: A request whose offset is greater than or equal to `cfg_word_count` produces `done` together with `err` one cycle after acceptance. It causes no chip-select frame and no SCK edge.
- R2: An accepted request first sends a frame of exactly 8 bits, equal to the write-enable opcode 0x06. Chip select then stays high for at least one clock before the write frame starts.
- R3: The write frame is the 8-bit opcode, then the address, then 16 data bits. It is 32 bits long when `cfg_addr16`=0 (8 address bits) and 40 bits long when `cfg_addr16`=1 (16 address bits).
- R4: The address field is the word offset multiplied by two, cut to the configured number of address bits.
- R5: When `cfg_addr16`=0 and the offset is 128 or more, the write opcode is 0x02 ORed with 0x08, which gives 0x0A. In every other case the write opcode is 0x02.
- R6: The data field is the request word with its upper and lower bytes exchanged, sent MSB first.
- R7: The bus uses SPI mode 0. SCK is low whenever chip select is high. MOSI changes only while SCK is low. Successive rising edges of SCK within a frame are 2*SCK_HALF clocks apart.
- R8: `done` rises exactly `cfg_delay`+1 clocks after chip select rises at the end of the write frame. `done` lasts one cycle, and `err` is low on a successful write.
- R9: A request raised while `busy` is high is ignored. It changes neither the frames sent nor the number of frames.
- R10: After reset, `spi_cs_n` is 1, `spi_sck` is 0, and `busy`, `done` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, sampled in ST_IDLE only |
| req_offset | input | OFFS_W | Word offset to write |
| req_data | input | DATA_W | Data word to write |
| cfg_word_count | input | OFFS_W | Device size in words |
| cfg_addr16 | input | 1 | 1: 16 address bits, 0: 8 address bits |
| cfg_delay | input | DELAY_W | Programming wait in clocks |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the device |
| busy | output | 1 | High while a request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Set with `done` when the offset is rejected |

## Verification
The assertions assume that `cfg_word_count`, `cfg_addr16` and `cfg_delay` stay constant from the acceptance of a request until its `done`. The reject and timer properties read these inputs live, and they would not hold if the inputs moved during a transaction. The bench sets all configuration inputs together with `req_valid` and holds them until `done` has been seen. It changes only `req_valid`, `req_offset` and `req_data` during the busy-ignore test. Every check is made at the bus pins: a bench monitor rebuilds each frame from the rising edges of SCK.

// File: rtl/eew_pkg.sv
package eew_pkg;

    localparam int EEW_OP_W     = 8;
    localparam int EEW_ADDR_MAX = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REJECT,
        ST_WREN,
        ST_STANDBY,
        ST_WRITE,
        ST_SETTLE,
        ST_DONE
    } eew_state_t;

endpackage

// File: rtl/eew_frame.sv
module eew_frame
    import eew_pkg::*;
#(
    parameter int          OFFS_W   = 16,
    parameter int          DATA_W   = 16,
    parameter int          FRAME_W  = 40,
    parameter int          LEN_W    = 6,
    parameter logic [7:0]  OP_WRITE = 8'h02,
    parameter logic [7:0]  OP_A8    = 8'h08
) (
    input  logic [OFFS_W-1:0]  offset,
    input  logic [DATA_W-1:0]  data,
    input  logic               addr16,
    output logic [FRAME_W-1:0] bits,
    output logic [LEN_W-1:0]   len
);
    localparam int NBYTES = DATA_W / 8;
    localparam int PAD_W  = EEW_ADDR_MAX - 8;

    logic [DATA_W-1:0]       swapped;
    logic [EEW_ADDR_MAX-1:0] byte_addr;
    logic                    a8;
    logic [EEW_OP_W-1:0]     opcode;

    for (genvar b = 0; b < NBYTES; b++) begin : g_swap
        assign swapped[b*8 +: 8] = data[(NBYTES-1-b)*8 +: 8];
    end

    assign byte_addr = {offset[EEW_ADDR_MAX-2:0], 1'b0};
    assign a8        = !addr16 && (offset >= OFFS_W'(128));
    assign opcode    = a8 ? (OP_WRITE | OP_A8) : OP_WRITE;

    always_comb begin
        if (addr16) begin
            bits = {opcode, byte_addr, swapped};
            len  = LEN_W'(EEW_OP_W + EEW_ADDR_MAX + DATA_W);
        end else begin
            bits = {opcode, byte_addr[7:0], swapped, {PAD_W{1'b0}}};
            len  = LEN_W'(EEW_OP_W + 8 + DATA_W);
        end
    end

endmodule

// File: rtl/eew_shifter.sv
module eew_shifter #(
    parameter int FRAME_W  = 40,
    parameter int LEN_W    = 6,
    parameter int SCK_HALF = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] load_bits,
    input  logic [LEN_W-1:0]   load_len,
    output logic               sck_o,
    output logic               mosi_o,
    output logic               done_o
);
    localparam int PH_W = $clog2(SCK_HALF + 1);

    logic [FRAME_W-1:0] shreg;
    logic [LEN_W-1:0]   left;
    logic [PH_W-1:0]    phase;
    logic               active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            left   <= '0;
            phase  <= '0;
            active <= 1'b0;
            sck_o  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start) begin
                shreg  <= load_bits;
                left   <= load_len;
                phase  <= '0;
                active <= 1'b1;
                sck_o  <= 1'b0;
            end else if (active) begin
                if (phase == PH_W'(SCK_HALF - 1)) begin
                    phase <= '0;
                    if (!sck_o) begin
                        sck_o <= 1'b1;
                    end else begin
                        sck_o <= 1'b0;
                        if (left == LEN_W'(1)) begin
                            active <= 1'b0;
                            done_o <= 1'b1;
                            shreg  <= '0;
                        end else begin
                            left  <= left - LEN_W'(1);
                            shreg <= shreg << 1;
                        end
                    end
                end else begin
                    phase <= phase + PH_W'(1);
                end
            end
        end
    end

    assign mosi_o = shreg[FRAME_W-1];

    // R7: data moves only while the clock line is low
    a_r7_mosi_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi_o) |-> !sck_o);

endmodule

// File: rtl/eew_timer.sv
module eew_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= value;
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign expired = (cnt == '0);

    // R8: the wait counts down one per clock
    a_r8_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - W'(1)));

endmodule

// File: rtl/eeprom_word_writer.sv
module eeprom_word_writer
    import eew_pkg::*;
#(
    parameter int         SCK_HALF = 2,
    parameter int         OFFS_W   = 16,
    parameter int         DATA_W   = 16,
    parameter int         DELAY_W  = 16,
    parameter logic [7:0] OP_WREN  = 8'h06,
    parameter logic [7:0] OP_WRITE = 8'h02,
    parameter logic [7:0] OP_A8    = 8'h08
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [OFFS_W-1:0]  req_offset,
    input  logic [DATA_W-1:0]  req_data,
    input  logic [OFFS_W-1:0]  cfg_word_count,
    input  logic               cfg_addr16,
    input  logic [DELAY_W-1:0] cfg_delay,
    output logic               spi_sck,
    output logic               spi_cs_n,
    output logic               spi_mosi,
    output logic               busy,
    output logic               done,
    output logic               err
);
    localparam int FRAME_W = EEW_OP_W + EEW_ADDR_MAX + DATA_W;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    eew_state_t state, nxt;

    logic [OFFS_W-1:0]  lat_off;
    logic [DATA_W-1:0]  lat_data;
    logic               lat_a16;
    logic               in_range;
    logic               accept;
    logic [FRAME_W-1:0] wr_bits;
    logic [LEN_W-1:0]   wr_len;
    logic [FRAME_W-1:0] sh_bits;
    logic [LEN_W-1:0]   sh_len;
    logic               sh_start;
    logic               sh_done;
    logic               tmr_load;
    logic               tmr_expired;

    assign in_range = (req_offset < cfg_word_count);
    assign accept   = (state == ST_IDLE) && req_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (req_valid) nxt = in_range ? ST_WREN : ST_REJECT;
            ST_REJECT:  nxt = ST_IDLE;
            ST_WREN:    if (sh_done) nxt = ST_STANDBY;
            ST_STANDBY: nxt = ST_WRITE;
            ST_WRITE:   if (sh_done) nxt = ST_SETTLE;
            ST_SETTLE:  if (tmr_expired) nxt = ST_DONE;
            ST_DONE:    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_off  <= '0;
            lat_data <= '0;
            lat_a16  <= 1'b0;
        end else if (accept) begin
            lat_off  <= req_offset;
            lat_data <= req_data;
            lat_a16  <= cfg_addr16;
        end
    end

    always_comb begin
        spi_cs_n = !((state == ST_WREN) || (state == ST_WRITE));
        busy     = (state != ST_IDLE);
        done     = (state == ST_DONE) || (state == ST_REJECT);
        err      = (state == ST_REJECT);
    end

    eew_frame #(
        .OFFS_W(OFFS_W), .DATA_W(DATA_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W),
        .OP_WRITE(OP_WRITE), .OP_A8(OP_A8)
    ) u_frame (
        .offset(lat_off), .data(lat_data), .addr16(lat_a16),
        .bits(wr_bits), .len(wr_len)
    );

    assign sh_start = (accept && in_range) || (state == ST_STANDBY);
    assign sh_bits  = (state == ST_IDLE) ? {OP_WREN, {(FRAME_W-EEW_OP_W){1'b0}}} : wr_bits;
    assign sh_len   = (state == ST_IDLE) ? LEN_W'(EEW_OP_W) : wr_len;

    eew_shifter #(
        .FRAME_W(FRAME_W), .LEN_W(LEN_W), .SCK_HALF(SCK_HALF)
    ) u_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start),
        .load_bits(sh_bits), .load_len(sh_len),
        .sck_o(spi_sck), .mosi_o(spi_mosi), .done_o(sh_done)
    );

    assign tmr_load = (state == ST_WRITE) && sh_done;

    eew_timer #(.W(DELAY_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .value(cfg_delay), .expired(tmr_expired)
    );

    // R1: out-of-range offset completes with error and no frame
    a_r1_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req_valid && req_offset >= cfg_word_count)
        |=> (done && err && spi_cs_n));

    // R7: clock idles low outside a frame
    a_r7_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: a request during a transaction leaves the captured word untouched
    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> ($stable(lat_off) && $stable(lat_data)));

    // R2: write-enable frame ends with a standby cycle
    a_r2_standby: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WREN && sh_done) |=> spi_cs_n);

endmodule

// File: tb/eeprom_word_writer_bench.sv
module eeprom_word_writer_bench;

    localparam int SCK_HALF = 2;
    localparam int NVEC     = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_offset = '0;
    logic [15:0] req_data = '0;
    logic [15:0] cfg_word_count = '0;
    logic        cfg_addr16 = 1'b0;
    logic [15:0] cfg_delay = '0;
    logic        spi_sck, spi_cs_n, spi_mosi, busy, done, err;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    eeprom_word_writer #(.SCK_HALF(SCK_HALF)) u_eeprom_word_writer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_offset(req_offset), .req_data(req_data),
        .cfg_word_count(cfg_word_count), .cfg_addr16(cfg_addr16),
        .cfg_delay(cfg_delay), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .busy(busy), .done(done), .err(err)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // offset, data, addr16, word_count, delay, expect_err
    localparam logic [57:0] VEC [NVEC] = '{
        {16'd5,    16'h1234, 1'b0, 16'd256,  8'd3, 1'b0},
        {16'd127,  16'hABCD, 1'b0, 16'd256,  8'd1, 1'b0},
        {16'd128,  16'h00FF, 1'b0, 16'd256,  8'd4, 1'b0},
        {16'd200,  16'h1111, 1'b0, 16'd200,  8'd2, 1'b1},
        {16'd201,  16'h2222, 1'b1, 16'd200,  8'd2, 1'b1},
        {16'd300,  16'h5A3C, 1'b1, 16'd1024, 8'd5, 1'b0},
        {16'd199,  16'h8001, 1'b0, 16'd200,  8'd0, 1'b0},
        {16'd1023, 16'hFFFF, 1'b1, 16'd1024, 8'd7, 1'b0}
    };

    // bus monitor, sampled on the falling clock edge
    logic        mon_clr = 1'b0;
    logic        prev_sck = 1'b0, prev_cs = 1'b1, prev_mosi = 1'b0;
    logic [39:0] cur = '0;
    int          clen = 0;
    int          nfr = 0;
    logic [39:0] fbits [2];
    int          flen [2];
    int          rise_cyc = 0, done_cyc = 0, last_rise = -1;
    int          per_bad = 0, mosi_bad = 0, idle_bad = 0, sck_edges = 0;

    always @(negedge clk) begin
        if (mon_clr) begin
            nfr = 0; clen = 0; cur = '0; per_bad = 0; mosi_bad = 0;
            idle_bad = 0; sck_edges = 0; last_rise = -1;
            fbits[0] = '0; fbits[1] = '0; flen[0] = 0; flen[1] = 0;
        end else begin
            if (spi_sck && !prev_sck) begin
                sck_edges = sck_edges + 1;
                if (!spi_cs_n) begin
                    cur  = {cur[38:0], spi_mosi};
                    clen = clen + 1;
                    if (last_rise >= 0 && (cyc - last_rise) != 2*SCK_HALF)
                        per_bad = per_bad + 1;
                    last_rise = cyc;
                end
            end
            if (spi_mosi != prev_mosi && spi_sck) mosi_bad = mosi_bad + 1;
            if (spi_cs_n && spi_sck) idle_bad = idle_bad + 1;
            if (spi_cs_n && !prev_cs) begin
                if (nfr < 2) begin
                    fbits[nfr] = cur;
                    flen[nfr]  = clen;
                end
                nfr = nfr + 1; cur = '0; clen = 0; last_rise = -1;
                rise_cyc = cyc;
            end
            if (done) done_cyc = cyc;
        end
        prev_sck = spi_sck; prev_cs = spi_cs_n; prev_mosi = spi_mosi;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [39:0] exp_write(input logic [15:0] off, input logic [15:0] d,
                                              input logic a16);
        logic [7:0]  op;
        logic [15:0] ba;
        logic [15:0] sw;
        ba = off << 1;
        sw = {d[7:0], d[15:8]};
        op = (!a16 && off >= 16'd128) ? 8'h0A : 8'h02;
        if (a16) return {op, ba, sw};
        return {8'h00, op, ba[7:0], sw};
    endfunction

    task automatic clear_mon();
        @(posedge clk); #1 mon_clr = 1'b1;
        @(posedge clk); #1 mon_clr = 1'b0;
    endtask

    logic got_done, got_err;

    task automatic run_req(input logic [15:0] off, input logic [15:0] d, input logic a16,
                           input logic [15:0] cnt, input logic [15:0] dly);
        clear_mon();
        @(negedge clk);
        req_offset = off; req_data = d; cfg_addr16 = a16;
        cfg_word_count = cnt; cfg_delay = dly; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        got_done = 1'b0; got_err = 1'b0;
        for (int i = 0; i < 4000 && !got_done; i++) begin
            if (done) begin got_done = 1'b1; got_err = err; end
            else @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=0x%0h expected=0x%0h", cyc, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(spi_cs_n == 1'b1, "R10 cs_n", spi_cs_n, 1);
        chk(spi_sck == 1'b0,  "R10 sck", spi_sck, 0);
        chk({busy, done, err} == 3'b000, "R10 busy/done/err", {busy, done, err}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] off, d, cnt;
            logic        a16, xerr;
            logic [7:0]  dly;
            {off, d, a16, cnt, dly, xerr} = VEC[v];
            run_req(off, d, a16, cnt, 16'(dly));
            chk(got_done, "R8 done seen", got_done, 1);
            chk(got_err == xerr, "R1 err flag", got_err, xerr);
            if (xerr) begin
                chk(nfr == 0, "R1 no frame", nfr, 0);
                chk(sck_edges == 0, "R1 no sck", sck_edges, 0);
            end else begin
                chk(nfr == 2, "R2 frame count", nfr, 2);
                chk(flen[0] == 8 && fbits[0][7:0] == 8'h06, "R2 wren frame",
                    {flen[0], fbits[0][7:0]}, {32'd8, 8'h06});
                chk(flen[1] == (a16 ? 40 : 32), "R3 write length", flen[1], a16 ? 40 : 32);
                // R4 R5 R6: opcode, doubled address and swapped data
                chk(fbits[1] == exp_write(off, d, a16), "R4 R5 R6 write frame",
                    fbits[1], exp_write(off, d, a16));
                chk(done_cyc - rise_cyc == int'(dly) + 1, "R8 delay",
                    done_cyc - rise_cyc, int'(dly) + 1);
                chk(per_bad == 0 && mosi_bad == 0 && idle_bad == 0, "R7 mode 0 timing",
                    per_bad + mosi_bad + idle_bad, 0);
            end
        end

        // R9: second request during busy is ignored
        clear_mon();
        @(negedge clk);
        req_offset = 16'd10; req_data = 16'h1357; cfg_addr16 = 1'b0;
        cfg_word_count = 16'd256; cfg_delay = 16'd2; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        req_offset = 16'd20; req_data = 16'h2468; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        got_done = 1'b0;
        for (int i = 0; i < 4000 && !got_done; i++) begin
            if (done) got_done = 1'b1;
            else @(negedge clk);
        end
        repeat (60) @(negedge clk);
        chk(nfr == 2, "R9 frame count", nfr, 2);
        chk(fbits[1] == exp_write(16'd10, 16'h1357, 1'b0), "R9 first word kept",
            fbits[1], exp_write(16'd10, 16'h1357, 1'b0));
        chk(busy == 1'b0, "R9 idle after", busy, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule